// File: doc/BRIEF.md
# Context Database Entry Decoder

This block walks a packed table of 10-bit entries describing where a suspended task's flip-flops sit in configuration memory. Each entry is either a column frame address or a per-register bit-position parameter, told apart by a 2-bit share tag in the upper bits. Frame entries are widened into full 32-bit configuration frame addresses and handed to a readback sequencer. One stored frame address stands for a pair of adjacent frames. Parameter entries are sent on to a state filter together with the frame they refer to and the computed bit offset of the register inside that frame.

A run starts with a one-cycle `start` pulse and an entry count. The decoder reads the table one entry at a time through a synchronous read port, where data returns one cycle after the read strobe. It holds a new frame address back until the sequencer has acknowledged the column it was given before. When the last entry has been consumed it raises `done` for one cycle.

The controller has four states. `ST_IDLE` waits for `start`. `ST_FETCH` strobes the database read. `ST_DECODE` classifies the returned entry and emits it. `ST_HOLD` parks a frame entry until the acknowledge arrives. The transitions are:

- `ST_IDLE` goes to `ST_FETCH` on `start` with a non-zero count.
- `ST_FETCH` always goes to `ST_DECODE`.
- `ST_DECODE` goes to `ST_HOLD` when a frame entry meets an unacknowledged column.
- `ST_DECODE` and `ST_HOLD` go to `ST_FETCH` after consuming an entry that is not the last one.
- `ST_DECODE` and `ST_HOLD` go to `ST_IDLE` after consuming the last entry.

Top module: `ctx_db_decoder`

## Requirements
- R1: After reset, `frame_req`, `param_valid`, `done`, `busy` and `db_rd` are all low.
- R2: An entry whose bits 9:8 are 00 is a frame entry and produces exactly one `frame_req` pulse. Any other tag value produces at most one `param_valid` pulse. The two outputs never pulse in the same cycle.
- R3: A frame entry expands to a 32-bit address as follows. Bits 7:2 of the entry, zero-extended, go to address bits 24:17. Bits 1:0 of the entry, zero-extended, go to address bits 16:9. All other address bits are 0. For example, entry 0x029 gives 0x00140200 and entry 0x035 gives 0x001A0200.
- R4: The decoder has at most one unacknowledged frame request at a time. A frame entry that arrives while a request is still unacknowledged is not issued until `frame_ack` is seen. An acknowledge that arrives in the same cycle as the entry releases it at once.
- R5: A parameter pulse carries the following fields:
  - `param_share`, taken from entry bits 9:8.
  - `param_odd`, taken from bit 7 (0 means an even column, 1 an odd column).
  - `param_row`, taken from bits 6:0.
  - `param_frame`, which is the current column's first frame for tags 01 and 11, and its second frame (minor field plus one) for tag 10.
- R6: `param_bit_idx` equals 118 + 40*(79 - row) for an even column and 116 + 40*(79 - row) for an odd column.
- R7: A parameter entry with row above 79 produces no pulse, but it still counts as a consumed entry.
- R8: Within a run, a parameter entry that comes before any frame entry reports `param_frame` = 0.
- R9: Entries are read in order from address 0 to count-1, with one `db_rd` strobe per entry, and only while `busy` is high.
- R10: `done` pulses for exactly one cycle. It comes in the same cycle as the output of the last entry, or one cycle after `start` when the count is 0.
- R11: A `start` pulse while the decoder is busy is ignored. The run in progress emits exactly its own entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| entry_count | input | ADDR_W+1 | Number of entries to walk, sampled with start |
| db_rd | output | 1 | Database read strobe |
| db_addr | output | ADDR_W | Database read address |
| db_data | input | 10 | Entry returned one cycle after db_rd |
| frame_req | output | 1 | One-cycle frame address request |
| frame_addr | output | 32 | Expanded frame address, valid with frame_req |
| frame_ack | input | 1 | Sequencer finished the outstanding column |
| param_valid | output | 1 | One-cycle parameter pulse |
| param_share | output | 2 | Share tag of the parameter |
| param_odd | output | 1 | Column parity of the parameter |
| param_row | output | 7 | Row parameter |
| param_bit_idx | output | 12 | Bit offset of the register inside its frame |
| param_frame | output | 32 | Frame the parameter refers to |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run in progress |

## Verification
The bench sweeps all 256 frame-entry bodies under several acknowledge delays. A decoder that swapped or misplaced the major and minor fields would produce wrong addresses. A decoder that issued a new column before the acknowledge arrived would trip the bench's outstanding-request tracker.

A second sweep covers every parameter byte under each of the three share tags. It catches a missing minor-plus-one for tag 10, an inverted parity base, and rows 80 to 127 leaking through the row check.

Directed runs cover the remaining corner cases:
- Parameters placed before the first frame entry, which a decoder that kept the previous run's column would report with a stale frame.
- A spurious `start` in the middle of a run, which a decoder that restarted would expose by repeating entries.
- A count of zero, which must still give its `done` pulse.

// File: rtl/ctx_db_pkg.sv
package ctx_db_pkg;

    localparam int ENTRY_W = 10;
    localparam int BODY_W  = 8;
    localparam int FRAME_W = 32;

    localparam logic [1:0] TAG_FRAME  = 2'b00;
    localparam logic [1:0] TAG_FIRST  = 2'b01;
    localparam logic [1:0] TAG_SECOND = 2'b10;
    localparam logic [1:0] TAG_BOTH   = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_HOLD   = 2'd3
    } dec_state_e;

endpackage

// File: rtl/ctx_frame_expand.sv
module ctx_frame_expand #(
    parameter int MJA_W    = 6,
    parameter int MNA_W    = 2,
    parameter int BLK_TYPE = 0
) (
    input  logic [MJA_W+MNA_W-1:0] body,
    output logic [31:0]            first_addr,
    output logic [31:0]            second_addr
);
    localparam int FIELD_W = 8;
    localparam int MJA_PAD = FIELD_W - MJA_W;
    localparam int MNA_PAD = FIELD_W - MNA_W;

    logic [FIELD_W-1:0] major_f;
    logic [FIELD_W-1:0] minor_f;
    logic [FIELD_W-1:0] minor_n;

    always_comb begin
        major_f     = {{MJA_PAD{1'b0}}, body[MJA_W+MNA_W-1:MNA_W]};
        minor_f     = {{MNA_PAD{1'b0}}, body[MNA_W-1:0]};
        minor_n     = minor_f + 8'd1;
        first_addr  = {5'b0, 2'(BLK_TYPE), major_f, minor_f, 9'b0};
        second_addr = {5'b0, 2'(BLK_TYPE), major_f, minor_n, 9'b0};
    end
endmodule

// File: rtl/ctx_bit_index.sv
module ctx_bit_index #(
    parameter int ROW_W     = 7,
    parameter int IDX_W     = 12,
    parameter int MAX_ROW   = 79,
    parameter int ROW_PITCH = 40,
    parameter int BASE_EVEN = 118,
    parameter int BASE_ODD  = 116
) (
    input  logic [ROW_W-1:0] row,
    input  logic             odd,
    output logic [IDX_W-1:0] bit_idx,
    output logic             row_ok
);
    logic [IDX_W-1:0] span;
    logic [IDX_W-1:0] base;

    always_comb begin
        row_ok  = ({{(IDX_W-ROW_W){1'b0}}, row} <= IDX_W'(MAX_ROW));
        span    = IDX_W'(MAX_ROW) - {{(IDX_W-ROW_W){1'b0}}, row};
        base    = odd ? IDX_W'(BASE_ODD) : IDX_W'(BASE_EVEN);
        bit_idx = base + IDX_W'(ROW_PITCH) * span;
    end
endmodule

// File: rtl/ctx_db_decoder.sv
module ctx_db_decoder
    import ctx_db_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MJA_W     = 6,
    parameter int MNA_W     = 2,
    parameter int ROW_W     = 7,
    parameter int IDX_W     = 12,
    parameter int MAX_ROW   = 79,
    parameter int ROW_PITCH = 40,
    parameter int BASE_EVEN = 118,
    parameter int BASE_ODD  = 116
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   entry_count,
    output logic              db_rd,
    output logic [ADDR_W-1:0] db_addr,
    input  logic [9:0]        db_data,
    output logic              frame_req,
    output logic [31:0]       frame_addr,
    input  logic              frame_ack,
    output logic              param_valid,
    output logic [1:0]        param_share,
    output logic              param_odd,
    output logic [6:0]        param_row,
    output logic [11:0]       param_bit_idx,
    output logic [31:0]       param_frame,
    output logic              done,
    output logic              busy
);
    localparam int CNT_W = ADDR_W + 1;

    dec_state_e state_q, state_d;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BODY_W-1:0] hold_q;
    logic [31:0]       col_first_q;
    logic [31:0]       col_second_q;
    logic              outstanding_q;

    logic [1:0]        tag;
    logic              is_frame;
    logic              last;
    logic              wait_ack;
    logic              issue;
    logic              advance;
    logic              accept;
    logic [BODY_W-1:0] src_body;
    logic [31:0]       exp_first;
    logic [31:0]       exp_second;
    logic [IDX_W-1:0]  calc_idx;
    logic              row_ok;

    ctx_frame_expand #(
        .MJA_W    (MJA_W),
        .MNA_W    (MNA_W),
        .BLK_TYPE (0)
    ) u_expand (
        .body        (src_body),
        .first_addr  (exp_first),
        .second_addr (exp_second)
    );

    ctx_bit_index #(
        .ROW_W     (ROW_W),
        .IDX_W     (IDX_W),
        .MAX_ROW   (MAX_ROW),
        .ROW_PITCH (ROW_PITCH),
        .BASE_EVEN (BASE_EVEN),
        .BASE_ODD  (BASE_ODD)
    ) u_bitidx (
        .row     (db_data[ROW_W-1:0]),
        .odd     (db_data[7]),
        .bit_idx (calc_idx),
        .row_ok  (row_ok)
    );

    always_comb begin
        tag      = db_data[9:8];
        is_frame = (tag == TAG_FRAME);
        last     = ((idx_q + CNT_W'(1)) == cnt_q);
        wait_ack = outstanding_q && !frame_ack;
        accept   = (state_q == ST_IDLE) && start && (entry_count != '0);
        issue    = ((state_q == ST_DECODE) && is_frame && !wait_ack)
                || ((state_q == ST_HOLD) && frame_ack);
        advance  = ((state_q == ST_DECODE) && !(is_frame && wait_ack))
                || ((state_q == ST_HOLD) && frame_ack);
        src_body = (state_q == ST_HOLD) ? hold_q : db_data[BODY_W-1:0];
        db_rd    = (state_q == ST_FETCH);
        db_addr  = idx_q[ADDR_W-1:0];
        busy     = (state_q != ST_IDLE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                if (is_frame && wait_ack) state_d = ST_HOLD;
                else if (last)            state_d = ST_IDLE;
                else                      state_d = ST_FETCH;
            end
            ST_HOLD: begin
                if (frame_ack) state_d = last ? ST_IDLE : ST_FETCH;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q <= '0;
                cnt_q <= entry_count;
            end else if (advance) begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_req     <= 1'b0;
            frame_addr    <= '0;
            param_valid   <= 1'b0;
            param_share   <= '0;
            param_odd     <= 1'b0;
            param_row     <= '0;
            param_bit_idx <= '0;
            param_frame   <= '0;
            done          <= 1'b0;
            hold_q        <= '0;
            col_first_q   <= '0;
            col_second_q  <= '0;
            outstanding_q <= 1'b0;
        end else begin
            frame_req   <= 1'b0;
            param_valid <= 1'b0;
            done        <= ((state_q == ST_IDLE) && start && (entry_count == '0))
                        || (advance && last);
            if (accept) begin
                col_first_q  <= '0;
                col_second_q <= '0;
            end
            if (state_q == ST_DECODE) hold_q <= db_data[BODY_W-1:0];
            if (issue) begin
                frame_req     <= 1'b1;
                frame_addr    <= exp_first;
                col_first_q   <= exp_first;
                col_second_q  <= exp_second;
                outstanding_q <= 1'b1;
            end else if (frame_ack) begin
                outstanding_q <= 1'b0;
            end
            if ((state_q == ST_DECODE) && !is_frame && row_ok) begin
                param_valid   <= 1'b1;
                param_share   <= tag;
                param_odd     <= db_data[7];
                param_row     <= db_data[6:0];
                param_bit_idx <= calc_idx;
                param_frame   <= (tag == TAG_SECOND) ? col_second_q : col_first_q;
            end
        end
    end
endmodule

// File: rtl/ctx_db_decoder_chk.sv
module ctx_db_decoder_chk #(
    parameter int ADDR_W  = 8,
    parameter int MAX_ROW = 79
) (
    input logic              clk,
    input logic              rst_n,
    input logic              db_rd,
    input logic              busy,
    input logic              frame_req,
    input logic [31:0]       frame_addr,
    input logic              param_valid,
    input logic [1:0]        param_share,
    input logic [6:0]        param_row,
    input logic              done
);
    // R2
    no_dual_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_req && param_valid));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    rd_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_rd |-> busy);

    // R3
    frame_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req |-> (frame_addr[31:25] == 7'd0) && (frame_addr[8:0] == 9'd0)
                      && (frame_addr[24:23] == 2'd0) && (frame_addr[16:12] == 5'd0));

    // R7
    row_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        param_valid |-> (param_row <= 7'(MAX_ROW)));

    // R5
    share_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        param_valid |-> (param_share != 2'b00));
endmodule

bind ctx_db_decoder ctx_db_decoder_chk #(
    .ADDR_W  (ADDR_W),
    .MAX_ROW (MAX_ROW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .db_rd       (db_rd),
    .busy        (busy),
    .frame_req   (frame_req),
    .frame_addr  (frame_addr),
    .param_valid (param_valid),
    .param_share (param_share),
    .param_row   (param_row),
    .done        (done)
);

// File: tb/ctx_db_decoder_bench.sv
module ctx_db_decoder_bench;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W:0]   entry_count = '0;
    logic              db_rd;
    logic [ADDR_W-1:0] db_addr;
    logic [9:0]        db_data = '0;
    logic              frame_req;
    logic [31:0]       frame_addr;
    logic              frame_ack = 1'b0;
    logic              param_valid;
    logic [1:0]        param_share;
    logic              param_odd;
    logic [6:0]        param_row;
    logic [11:0]       param_bit_idx;
    logic [31:0]       param_frame;
    logic              done;
    logic              busy;

    always #4 clk = ~clk;

    ctx_db_decoder #(.ADDR_W(ADDR_W)) u_ctx_db_decoder (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_count(entry_count),
        .db_rd(db_rd), .db_addr(db_addr), .db_data(db_data),
        .frame_req(frame_req), .frame_addr(frame_addr), .frame_ack(frame_ack),
        .param_valid(param_valid), .param_share(param_share), .param_odd(param_odd),
        .param_row(param_row), .param_bit_idx(param_bit_idx), .param_frame(param_frame),
        .done(done), .busy(busy)
    );

    logic [9:0] mem [0:DEPTH-1];
    always @(posedge clk) if (db_rd) db_data <= mem[db_addr];

    // expected event list
    bit          e_frame [0:DEPTH-1];
    logic [31:0] e_addr  [0:DEPTH-1];
    logic [1:0]  e_share [0:DEPTH-1];
    logic        e_odd   [0:DEPTH-1];
    logic [6:0]  e_row   [0:DEPTH-1];
    logic [11:0] e_idx   [0:DEPTH-1];
    int exp_n, ev_ptr, rd_ptr, run_n, ack_delay;
    bit done_seen, in_run;
    int tb_total = 0, tb_bad = 0, mon_total = 0, mon_bad = 0;

    task automatic build_expected(input int n);
        logic [31:0] cur;
        cur = 32'd0;
        exp_n = 0;
        for (int i = 0; i < n; i++) begin
            logic [9:0] e;
            e = mem[i];
            if (e[9:8] == 2'b00) begin
                cur = (32'(e[7:2]) << 17) | (32'(e[1:0]) << 9);
                e_frame[exp_n] = 1'b1;
                e_addr[exp_n]  = cur;
                exp_n++;
            end else if (e[6:0] <= 7'd79) begin
                e_frame[exp_n] = 1'b0;
                e_share[exp_n] = e[9:8];
                e_odd[exp_n]   = e[7];
                e_row[exp_n]   = e[6:0];
                e_idx[exp_n]   = 12'((e[7] ? 116 : 118) + 40 * (79 - int'(e[6:0])));
                e_addr[exp_n]  = (cur == 0) ? 32'd0
                               : ((e[9:8] == 2'b10) ? cur + 32'h200 : cur);
                exp_n++;
            end
        end
    endtask

    // monitor and acknowledge driver
    initial begin
        bit pending = 1'b0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            frame_ack = 1'b0;
            if (in_run && db_rd) begin
                mon_total++;
                if (int'(db_addr) != rd_ptr || rd_ptr >= run_n) begin
                    mon_bad++;
                    $display("FAIL R9 read addr act=%0d exp=%0d", db_addr, rd_ptr);
                end
                rd_ptr++;
            end
            if (frame_req) begin
                mon_total++;
                if (pending) begin
                    mon_bad++;
                    $display("FAIL R4 request while unacked act=1 exp=0");
                end
                pending = 1'b1;
                cnt = ack_delay;
            end else if (pending) begin
                if (cnt == 0) begin
                    frame_ack = 1'b1;
                    pending = 1'b0;
                end else cnt--;
            end
            if (frame_req || param_valid) begin
                mon_total++;
                if (ev_ptr >= exp_n) begin
                    mon_bad++;
                    $display("FAIL R11 extra event act=%0d exp=%0d", ev_ptr + 1, exp_n);
                end else if (frame_req) begin
                    if (!e_frame[ev_ptr] || frame_addr != e_addr[ev_ptr]) begin
                        mon_bad++;
                        $display("FAIL R3 frame act=%h exp=%h kind=%0d", frame_addr,
                                 e_addr[ev_ptr], e_frame[ev_ptr]);
                    end
                end else begin
                    if (e_frame[ev_ptr] || param_share != e_share[ev_ptr]
                        || param_odd != e_odd[ev_ptr] || param_row != e_row[ev_ptr]
                        || param_frame != e_addr[ev_ptr]) begin
                        mon_bad++;
                        $display("FAIL R5 param act=%0d/%0d/%0d/%h exp=%0d/%0d/%0d/%h",
                                 param_share, param_odd, param_row, param_frame,
                                 e_share[ev_ptr], e_odd[ev_ptr], e_row[ev_ptr], e_addr[ev_ptr]);
                    end
                    mon_total++;
                    if (!e_frame[ev_ptr] && param_bit_idx != e_idx[ev_ptr]) begin
                        mon_bad++;
                        $display("FAIL R6 bit index act=%0d exp=%0d", param_bit_idx, e_idx[ev_ptr]);
                    end
                end
                ev_ptr++;
            end
            if (done) begin
                mon_total++;
                if (ev_ptr != exp_n || rd_ptr != run_n) begin
                    mon_bad++;
                    $display("FAIL R10 done early events act=%0d exp=%0d reads act=%0d exp=%0d",
                             ev_ptr, exp_n, rd_ptr, run_n);
                end
                done_seen = 1'b1;
            end
        end
    end

    task automatic do_run(input int n, input int delay, input bit poke);
        int waited;
        build_expected(n);
        ack_delay = delay; ev_ptr = 0; rd_ptr = 0; run_n = n;
        done_seen = 1'b0; in_run = 1'b1;
        @(negedge clk);
        start = 1'b1; entry_count = (ADDR_W+1)'(n);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1; entry_count = (ADDR_W+1)'(2);
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done_seen && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (12) @(negedge clk);
        tb_total++;
        if (!done_seen || ev_ptr != exp_n) begin
            tb_bad++;
            $display("FAIL R10 run end done=%0d events act=%0d exp=%0d", done_seen, ev_ptr, exp_n);
        end
        in_run = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", tb_total + mon_total + 1, tb_bad + mon_bad + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        tb_total++;
        if (frame_req || param_valid || done || busy || db_rd) begin
            tb_bad++;
            $display("FAIL R1 reset outputs act=%b%b%b%b%b exp=00000",
                     frame_req, param_valid, done, busy, db_rd);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // directed: early parameter (R8), known addresses (R3), dropped row (R7), R11 poke
        mem[0] = 10'b01_0_1001111;
        mem[1] = 10'b00_00101001;
        mem[2] = 10'b11_1_1001111;
        mem[3] = 10'b00_00110101;
        mem[4] = 10'b11_0_1001111;
        mem[5] = 10'b01_0_1010000;
        mem[6] = 10'b10_1_0000000;
        do_run(7, 5, 1'b1);

        // R3 R4 R2: every frame body, two acknowledge delays
        for (int i = 0; i < DEPTH; i++) mem[i] = {2'b00, 8'(i)};
        do_run(DEPTH, 0, 1'b0);
        do_run(DEPTH, 3, 1'b0);

        // R5 R6 R7: every parameter byte under each share tag
        for (int f = 1; f < 4; f++) begin
            mem[0] = {2'b00, 8'(f * 37 + 1)};
            for (int i = 1; i < DEPTH; i++) mem[i] = {2'(f), 8'(i)};
            do_run(DEPTH, f, 1'b0);
        end

        // R10: zero and one entry runs
        do_run(0, 0, 1'b0);
        mem[0] = 10'b10_0_0101000;
        do_run(1, 0, 1'b0);

        $display("test done: total=%0d bad=%0d", tb_total + mon_total, tb_bad + mon_bad);
        $finish;
    end
endmodule